// File: doc/BRIEF.md
# Byte-Lane RAM with Single-Cycle Misaligned Word Access

This block is a synchronous on-chip RAM on a 16-bit data bus with a byte address. Each cycle it performs one access. The active-low low-byte strobe, address bit 0 and a read/write line together pick the access kind. The kinds are a byte access to an even address, a byte access to an odd address, an aligned word and a misaligned word. Every kind, including the misaligned word, finishes in a single cycle.

Internally the storage is split into an even bank and an odd bank, each one byte wide. The even bank always sits on data bits 15:8 and the odd bank on bits 7:0. A misaligned word at an odd address uses odd bank row r and even bank row r+1. That places the addressed byte on the low half of the bus and the following byte on the high half, which swaps the lanes relative to an aligned word. Read data is registered. A 3-bit access-type code is decoded from the inputs of the current cycle and is output so the access can be observed.

Top module: `lane_ram`

## Requirements
- R1: Strobe high with address bit 0 low is a byte access to the even address. It uses data bits 15:8, and on a read bits 7:0 return zero.
- R2: Strobe low with address bit 0 high is a byte access to the odd address. It uses data bits 7:0, and on a read bits 15:8 return zero.
- R3: Strobe low with address bit 0 low is an aligned word. The byte at the even address is on bits 15:8 and the byte at address+1 is on bits 7:0.
- R4: Strobe high with address bit 0 high is a misaligned word, done in one cycle. The byte at the addressed odd location is on bits 7:0 and the byte at address+1 is on bits 15:8.
- R5: A misaligned word at the highest byte address wraps, so its high byte is byte address 0.
- R6: A byte write leaves the other byte of the same word unchanged.
- R7: Read data appears in the cycle after the request. After a write cycle the read data is zero.
- R8: The access-type output is decoded from the current inputs. Bit 2 is 1 for a write (read/write line low). Bits 1:0 are 0 for an even byte, 1 for an odd byte, 2 for an aligned word and 3 for a misaligned word.
- R9: While reset is low, read data is zero and write requests change no memory content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and read capture on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read path; blocks writes |
| addr | input | ADDR_W | Byte address |
| lo_strobe_n | input | 1 | Active-low low-byte strobe |
| is_read | input | 1 | 1 = read, 0 = write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, unused lanes zero |
| acc_code | output | 3 | Decoded access type {write, kind} |

## Verification
The bench aims misaligned words at the very top of memory. A design that failed to wrap the row would read or write past the even bank instead of byte 0. It mixes byte writes with word reads of the same word, which exposes any lane enable that also writes the neighbouring byte. It compares lane placement for all four strobe/address-bit combinations against a flat byte model, so a design that swapped lanes on aligned words or failed to swap them on misaligned words returns byte-reversed data. It also issues writes during reset and reads them back afterwards to confirm that nothing was stored.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;

  typedef enum logic [1:0] {
    ACC_EVEN = 2'd0,
    ACC_ODD  = 2'd1,
    ACC_WORD = 2'd2,
    ACC_SWAP = 2'd3
  } acc_kind_t;

  // strobe/address-bit-0 pair to access kind
  function automatic acc_kind_t kind_of(input logic strobe_n, input logic a0);
    case ({strobe_n, a0})
      2'b10:   return ACC_EVEN;
      2'b01:   return ACC_ODD;
      2'b00:   return ACC_WORD;
      default: return ACC_SWAP;
    endcase
  endfunction

  // even bank drives the high lane
  function automatic logic uses_high(input acc_kind_t k);
    return k != ACC_ODD;
  endfunction

  // odd bank drives the low lane
  function automatic logic uses_low(input acc_kind_t k);
    return k != ACC_EVEN;
  endfunction

endpackage

// File: rtl/lane_ram_decode.sv
module lane_ram_decode
  import lane_ram_pkg::*;
(
  input  logic       lo_strobe_n,
  input  logic       a0,
  input  logic       is_read,
  output acc_kind_t  kind,
  output logic [1:0] lane_use,
  output logic [2:0] acc_code
);
  always_comb begin
    kind        = kind_of(lo_strobe_n, a0);
    lane_use[1] = uses_high(kind);
    lane_use[0] = uses_low(kind);
    acc_code    = {~is_read, kind};
  end
endmodule

// File: rtl/lane_ram_bank.sv
module lane_ram_bank #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);
  localparam int ROWS = 1 << ROW_W;

  logic [7:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) cells[row] <= wbyte;
    rbyte <= cells[row];
  end
endmodule

// File: rtl/lane_ram.sv
module lane_ram
  import lane_ram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lo_strobe_n,
  input  logic              is_read,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic [2:0]        acc_code
);
  localparam int ROW_W = ADDR_W - 1;
  localparam int LANES = 2;

  acc_kind_t              kind;
  logic [LANES-1:0]       lane_use;
  logic [ROW_W-1:0]       base_row;
  logic [ROW_W-1:0]       even_row;
  logic [ROW_W-1:0]       odd_row;
  logic [LANES-1:0][ROW_W-1:0] bank_row;
  logic [LANES-1:0][7:0]  bank_wd;
  logic [LANES-1:0][7:0]  bank_rd;
  logic [LANES-1:0]       bank_we;
  logic [LANES-1:0]       rd_mask_q;

  lane_ram_decode u_decode (
    .lo_strobe_n (lo_strobe_n),
    .a0          (addr[0]),
    .is_read     (is_read),
    .kind        (kind),
    .lane_use    (lane_use),
    .acc_code    (acc_code)
  );

  // row steering: a misaligned word takes the next even row
  always_comb begin
    base_row = addr[ADDR_W-1:1];
    odd_row  = base_row;
    even_row = (kind == ACC_SWAP) ? ROW_W'(base_row + 1'b1) : base_row;
    bank_row[1] = even_row;
    bank_row[0] = odd_row;
  end

  // lane index 1 = even bank = bits 15:8, index 0 = odd bank = bits 7:0
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    always_comb begin
      bank_we[b] = rst_n & ~is_read & lane_use[b];
      bank_wd[b] = wdata[8*b +: 8];
    end

    lane_ram_bank #(.ROW_W(ROW_W)) u_bank (
      .clk   (clk),
      .wr_en (bank_we[b]),
      .row   (bank_row[b]),
      .wbyte (bank_wd[b]),
      .rbyte (bank_rd[b])
    );

    assign rdata[8*b +: 8] = bank_rd[b] & {8{rd_mask_q[b]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_mask_q <= '0;
    else        rd_mask_q <= is_read ? lane_use : '0;
  end
endmodule

// File: rtl/lane_ram_chk.sv
module lane_ram_chk #(
  parameter int ROW_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             is_read,
  input logic [2:0]       acc_code,
  input logic [15:0]      rdata,
  input logic [ROW_W-1:0] even_row,
  input logic [ROW_W-1:0] odd_row
);
  // R1
  even_byte_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_read && acc_code[1:0] == 2'd0) |=> rdata[7:0] == 8'h00);

  // R2
  odd_byte_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_read && acc_code[1:0] == 2'd1) |=> rdata[15:8] == 8'h00);

  // R3
  aligned_same_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_code[1:0] != 2'd3 |-> even_row == odd_row);

  // R4
  swap_next_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_code[1:0] == 2'd3 |-> even_row == ROW_W'(odd_row + 1'b1));

  // R7
  write_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_read |=> rdata == 16'h0000);

  // R8
  write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_code[2] == !is_read);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> rdata == 16'h0000);
endmodule

bind lane_ram lane_ram_chk #(.ROW_W(ROW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .is_read  (is_read),
  .acc_code (acc_code),
  .rdata    (rdata),
  .even_row (even_row),
  .odd_row  (odd_row)
);

// File: tb/lane_ram_test.sv
`timescale 1ns/1ps
module lane_ram_test;
  localparam int AW    = 10;
  localparam int BYTES = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          lo_strobe_n = 1'b1;
  logic          is_read = 1'b1;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [2:0]    acc_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] model [BYTES];

  always #10 clk = ~clk;

  lane_ram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .lo_strobe_n(lo_strobe_n),
    .is_read(is_read), .wdata(wdata), .rdata(rdata), .acc_code(acc_code)
  );

  // R8 table: {strobe_n, a0} -> kind
  function automatic logic [1:0] exp_kind(input logic sn, input logic a0);
    if (sn && !a0) return 2'd0;
    if (!sn && a0) return 2'd1;
    if (!sn && !a0) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [15:0] model_read(input logic [1:0] k, input logic [AW-1:0] a);
    logic [AW-1:0] nxt;
    nxt = a + 1'b1;
    case (k)
      2'd0:    return {model[a], 8'h00};
      2'd1:    return {8'h00, model[a]};
      2'd2:    return {model[a], model[nxt]};
      default: return {model[nxt], model[a]};
    endcase
  endfunction

  task automatic model_write(input logic [1:0] k, input logic [AW-1:0] a, input logic [15:0] d);
    logic [AW-1:0] nxt;
    nxt = a + 1'b1;
    case (k)
      2'd0: model[a] = d[15:8];
      2'd1: model[a] = d[7:0];
      2'd2: begin model[a] = d[15:8]; model[nxt] = d[7:0]; end
      default: begin model[a] = d[7:0]; model[nxt] = d[15:8]; end
    endcase
  endtask

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic rd, input logic sn, input logic [AW-1:0] a,
                       input logic [15:0] wd, input string tag_in);
    logic [1:0]  k;
    logic [15:0] exp;
    string       tag;
    @(negedge clk);
    is_read = rd; lo_strobe_n = sn; addr = a; wdata = wd;
    k = exp_kind(sn, a[0]);
    #1;
    check(acc_code === {~rd, k}, "R8", {13'd0, acc_code}, {13'd0, ~rd, k});
    exp = rd ? model_read(k, a) : 16'h0000;
    if (tag_in != "") tag = tag_in;
    else if (!rd) tag = "R7";
    else if (k == 2'd0) tag = "R1";
    else if (k == 2'd1) tag = "R2";
    else if (k == 2'd2) tag = "R3";
    else if (a == AW'(BYTES - 1)) tag = "R5";
    else tag = "R4";
    @(posedge clk);
    #5;
    check(rdata === exp, tag, rdata, exp);
    if (!rd) model_write(k, a, wd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R9: output quiet in reset
    @(posedge clk); #5;
    check(rdata === 16'h0000, "R9", rdata, 16'h0000);
    @(negedge clk) rst_n = 1'b1;

    // fill memory with aligned words
    for (int r = 0; r < BYTES / 2; r++)
      do_op(1'b0, 1'b0, AW'(2 * r), 16'(r * 16'h0107 + 16'h5a3c), "R7");

    // R3 directed aligned read
    do_op(1'b1, 1'b0, AW'(8), 16'h0, "R3");
    // R4 directed misaligned write then aligned reads of both words
    do_op(1'b0, 1'b1, AW'(21), 16'hbeef, "R4");
    do_op(1'b1, 1'b0, AW'(20), 16'h0, "R4");
    do_op(1'b1, 1'b0, AW'(22), 16'h0, "R4");
    do_op(1'b1, 1'b1, AW'(21), 16'h0, "R4");
    // R5 wrap at top
    do_op(1'b0, 1'b1, AW'(BYTES - 1), 16'hc3a5, "R5");
    do_op(1'b1, 1'b0, AW'(0), 16'h0, "R5");
    do_op(1'b1, 1'b1, AW'(BYTES - 1), 16'h0, "R5");
    // R6 byte writes keep the neighbour byte
    do_op(1'b0, 1'b1, AW'(40), 16'h1177, "R6");
    do_op(1'b1, 1'b0, AW'(40), 16'h0, "R6");
    do_op(1'b0, 1'b0, AW'(43), 16'h99aa, "R6");
    do_op(1'b1, 1'b0, AW'(42), 16'h0, "R6");

    // R9: write during reset is dropped
    @(negedge clk);
    rst_n = 1'b0; is_read = 1'b0; lo_strobe_n = 1'b0; addr = AW'(60); wdata = 16'hdead;
    #1 check(rdata === 16'h0000, "R9", rdata, 16'h0000);
    @(posedge clk); #5;
    check(rdata === 16'h0000, "R9", rdata, 16'h0000);
    @(negedge clk) rst_n = 1'b1; is_read = 1'b1;
    do_op(1'b1, 1'b0, AW'(60), 16'h0, "R9");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      if (($urandom % 8) == 0) a = AW'(BYTES - 1);
      do_op(1'($urandom), 1'($urandom), a, 16'($urandom), "");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule